// File: doc/BRIEF.md
# SRAM ECC Error Aggregator

This block collects the error pulses raised by the ECC checkers of up to 32 SRAM instances and turns them into state that software can read. Every SRAM has one correctable line and one uncorrectable line. The two severities are handled by two identical tracking paths. Each path holds:

- a sticky status bit per SRAM,
- a mask bit per SRAM,
- an 8-bit saturating error counter,
- a write-only clear register,
- an injection-enable bit per SRAM, which goes out to the SRAM wrappers so that they corrupt their own check bits.

Only the uncorrectable path raises an interrupt. Correctable errors are recorded and counted, but they stay silent.

Software reaches the block over a small register bus. A request is a valid/ready transfer. `req_ready` is high in every cycle outside reset, so a request is accepted in the cycle it is presented. Requests may be issued back to back, one per cycle. A read returns its data with `rsp_valid` exactly one cycle after it is accepted. The response has no back-pressure: the requester must always take it. A write gives no response. The error lines are plain level inputs, sampled on every rising clock edge, and a high bit counts as one error event in that cycle.

Top module: `ecc_err_aggregator`

## Requirements
- R1: After reset, every register reads 0, `inj_uncorr`, `inj_corr` and `irq_uncorr` are 0, and `req_ready` is 0 while `rst` is high.
- R2: The injection-enable registers are read/write at byte offset 0x10 (uncorrectable) and 0x24 (correctable). Bit i drives bit i of `inj_uncorr` or `inj_corr` directly, starting in the cycle after the write.
- R3: The status registers are read-only at 0x1C (uncorrectable) and 0x30 (correctable). Bit i is set by a high on error line i while mask bit i is 0, and it stays set until it is cleared.
- R4: The mask registers are read/write at 0x14 (uncorrectable) and 0x28 (correctable). A 1 in bit i stops error line i from setting status bit i and from adding to the counter.
- R5: The counters are at 0x18 (uncorrectable) and 0x2C (correctable). In each cycle a counter grows by the number of unmasked error lines that are high. It saturates at 255, and a write to its offset has no effect.
- R6: The clear registers are at 0x20 (uncorrectable) and 0x34 (correctable). Writing 1 to bit i clears status bit i. Any nonzero write also zeroes that path's counter. A clear register reads as 0.
- R7: When an unmasked error pulse arrives in the same cycle as a clear of the same bit, the status bit stays set. The counter then holds exactly the number of errors from that cycle.
- R8: `irq_uncorr` is a level equal to the OR of all uncorrectable status bits whose mask bit is 0. Correctable status never raises it.
- R9: A spare read/write register sits at 0x38. Any other offset reads 0 and ignores writes.
- R10: `req_ready` is 1 in every cycle outside reset. An accepted read raises `rsp_valid` for one cycle, one cycle later, and back-to-back reads return in order. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (6) | Byte address of the register |
| req_wdata | input | DW (32) | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW (32) | Read data |
| err_corr | input | N_SRAM (32) | Correctable error pulses, one per SRAM |
| err_uncorr | input | N_SRAM (32) | Uncorrectable error pulses, one per SRAM |
| inj_corr | output | N_SRAM (32) | Correctable injection enables to the SRAM wrappers |
| inj_uncorr | output | N_SRAM (32) | Uncorrectable injection enables to the SRAM wrappers |
| irq_uncorr | output | 1 | Level interrupt for unmasked uncorrectable errors |

## Verification
The bench goes after four corner cases.

- **Same-cycle clear and error.** An error pulse arrives in the very cycle that the same bit is cleared. A design that lets the clear win would silently lose that error.
- **Counter saturation.** The counter is driven past 255 with all 32 lines high at once. A counter that wraps would read a small value, and one that adds only one per cycle would read far below the expected count.
- **Mask behaviour.** Masking is tested both before a pulse and after a status bit is already set. A design that masks only the interrupt, or only the status, shows up as a wrong status, a wrong count or a wrong `irq_uncorr` level.
- **Register bus.** Back-to-back reads and writes to the read-only counter offset catch responses that are delayed, dropped or reordered, and counters that can be overwritten.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;
  localparam int N_SEV       = 2;   // tracking paths
  localparam int SEV_UNCORR  = 0;
  localparam int SEV_CORR    = 1;
  localparam int W_SEV_BASE  = 4;   // word index of byte 0x10
  localparam int SEV_STRIDE  = 5;   // words between the two paths
  localparam int OFS_INJ     = 0;
  localparam int OFS_MASK    = 1;
  localparam int OFS_CNT     = 2;
  localparam int OFS_STAT    = 3;
  localparam int OFS_CLR     = 4;
  localparam int W_SPARE     = 14;  // word index of byte 0x38
  localparam int MIN_AW      = 6;
endpackage

// File: rtl/ecc_cfg_reg.sv
module ecc_cfg_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/ecc_sev_tracker.sv
module ecc_sev_tracker #(
  parameter int N_SRAM = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRAM-1:0] err,
  input  logic [N_SRAM-1:0] mask,
  input  logic              clr_we,
  input  logic [N_SRAM-1:0] clr_data,
  output logic [N_SRAM-1:0] status,
  output logic [CNT_W-1:0]  count
);
  localparam int POP_W = $clog2(N_SRAM + 1);
  localparam int SUM_W = (CNT_W > POP_W ? CNT_W : POP_W) + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [N_SRAM-1:0] hit;
  logic [N_SRAM-1:0] clr_bits;
  logic [POP_W-1:0]  pop;
  logic [SUM_W-1:0]  base, sum;
  logic [CNT_W-1:0]  count_next;

  assign hit      = err & ~mask;
  assign clr_bits = clr_we ? clr_data : '0;

  always_comb begin
    pop = '0;
    for (int i = 0; i < N_SRAM; i++) pop = pop + POP_W'(hit[i]);
  end

  always_comb begin
    base = (clr_we && (|clr_data)) ? '0 : SUM_W'(count);
    sum  = base + SUM_W'(pop);
    count_next = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      count  <= '0;
    end else begin
      status <= (status & ~clr_bits) | hit;
      count  <= count_next;
    end
  end
endmodule

// File: rtl/ecc_agg_regif.sv
module ecc_agg_regif #(
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int NWORDS = 1 << (AW - 2)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [AW-1:0]              req_addr,
  input  logic [DW-1:0]              req_wdata,
  output logic                       rsp_valid,
  output logic [DW-1:0]              rsp_rdata,
  input  logic [NWORDS-1:0][DW-1:0]  rd_words,
  output logic [NWORDS-1:0]          wr_we,
  output logic [DW-1:0]              wr_data
);
  logic          accept;
  logic [AW-3:0] word;

  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;
  assign word      = req_addr[AW-1:2];
  assign wr_data   = req_wdata;

  always_comb begin
    wr_we = '0;
    if (accept && req_write) wr_we[word] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write) rsp_rdata <= rd_words[word];
    end
  end
endmodule

// File: rtl/ecc_err_aggregator.sv
module ecc_err_aggregator
  import ecc_agg_pkg::*;
#(
  parameter int N_SRAM = 32,
  parameter int DW     = 32,
  parameter int AW     = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [N_SRAM-1:0] err_corr,
  input  logic [N_SRAM-1:0] err_uncorr,
  output logic [N_SRAM-1:0] inj_corr,
  output logic [N_SRAM-1:0] inj_uncorr,
  output logic              irq_uncorr
);
  localparam int NWORDS = 1 << (AW - 2);

  initial begin
    if (AW < MIN_AW)    $error("AW too small for the register map");
    if (N_SRAM > DW)    $error("N_SRAM must not exceed DW");
    if (CNT_W > DW)     $error("CNT_W must not exceed DW");
  end

  logic [NWORDS-1:0][DW-1:0] rd_words;
  logic [NWORDS-1:0]         wr_we;
  logic [DW-1:0]             wr_data;
  logic [DW-1:0]             spare_q;

  logic [N_SRAM-1:0] sev_err    [N_SEV];
  logic [N_SRAM-1:0] sev_inj    [N_SEV];
  logic [N_SRAM-1:0] sev_mask   [N_SEV];
  logic [N_SRAM-1:0] sev_status [N_SEV];
  logic [CNT_W-1:0]  sev_count  [N_SEV];

  // aliases for the bound checker
  logic [N_SRAM-1:0] uc_status_w, uc_mask_w;
  logic [CNT_W-1:0]  uc_count_w;
  logic              uc_clr_we_w;

  ecc_agg_regif #(.AW(AW), .DW(DW)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rd_words  (rd_words),
    .wr_we     (wr_we),
    .wr_data   (wr_data)
  );

  assign sev_err[SEV_UNCORR] = err_uncorr;
  assign sev_err[SEV_CORR]   = err_corr;

  for (genvar s = 0; s < N_SEV; s++) begin : g_sev
    localparam int BASE = W_SEV_BASE + s * SEV_STRIDE;

    ecc_cfg_reg #(.W(N_SRAM)) u_inj (
      .clk (clk), .rst (rst),
      .we  (wr_we[BASE + OFS_INJ]),
      .d   (wr_data[N_SRAM-1:0]),
      .q   (sev_inj[s])
    );

    ecc_cfg_reg #(.W(N_SRAM)) u_mask (
      .clk (clk), .rst (rst),
      .we  (wr_we[BASE + OFS_MASK]),
      .d   (wr_data[N_SRAM-1:0]),
      .q   (sev_mask[s])
    );

    ecc_sev_tracker #(.N_SRAM(N_SRAM), .CNT_W(CNT_W)) u_trk (
      .clk      (clk),
      .rst      (rst),
      .err      (sev_err[s]),
      .mask     (sev_mask[s]),
      .clr_we   (wr_we[BASE + OFS_CLR]),
      .clr_data (wr_data[N_SRAM-1:0]),
      .status   (sev_status[s]),
      .count    (sev_count[s])
    );
  end

  ecc_cfg_reg #(.W(DW)) u_spare (
    .clk (clk), .rst (rst),
    .we  (wr_we[W_SPARE]),
    .d   (wr_data),
    .q   (spare_q)
  );

  always_comb begin
    rd_words = '0;
    for (int s = 0; s < N_SEV; s++) begin
      rd_words[W_SEV_BASE + s*SEV_STRIDE + OFS_INJ ][N_SRAM-1:0] = sev_inj[s];
      rd_words[W_SEV_BASE + s*SEV_STRIDE + OFS_MASK][N_SRAM-1:0] = sev_mask[s];
      rd_words[W_SEV_BASE + s*SEV_STRIDE + OFS_CNT ][CNT_W-1:0]  = sev_count[s];
      rd_words[W_SEV_BASE + s*SEV_STRIDE + OFS_STAT][N_SRAM-1:0] = sev_status[s];
    end
    rd_words[W_SPARE] = spare_q;
  end

  assign inj_uncorr = sev_inj[SEV_UNCORR];
  assign inj_corr   = sev_inj[SEV_CORR];
  assign irq_uncorr = |(sev_status[SEV_UNCORR] & ~sev_mask[SEV_UNCORR]);

  assign uc_status_w = sev_status[SEV_UNCORR];
  assign uc_mask_w   = sev_mask[SEV_UNCORR];
  assign uc_count_w  = sev_count[SEV_UNCORR];
  assign uc_clr_we_w = wr_we[W_SEV_BASE + SEV_UNCORR*SEV_STRIDE + OFS_CLR];
endmodule

// File: rtl/ecc_err_aggregator_chk.sv
module ecc_err_aggregator_chk #(
  parameter int N_SRAM = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              irq_uncorr,
  input logic [N_SRAM-1:0] err_uncorr,
  input logic [N_SRAM-1:0] uc_status,
  input logic [N_SRAM-1:0] uc_mask,
  input logic [CNT_W-1:0]  uc_count,
  input logic              uc_clr_we
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R10: read response exactly one cycle after acceptance, none otherwise
  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  p_no_stray_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);

  // R3: without a clear, no status bit ever drops
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !uc_clr_we |=> ((uc_status & $past(uc_status)) == $past(uc_status)));

  // R4: a newly set bit never comes from a masked line
  p_mask_block_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((uc_status & ~$past(uc_status) & $past(uc_mask)) == '0));

  // R5: saturated counter stays saturated until cleared
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (uc_count == CMAX && !uc_clr_we) |=> (uc_count == CMAX));

  // R7: every unmasked pulse is visible next cycle, clear or not
  p_err_beats_clr_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((uc_status & ($past(err_uncorr) & ~$past(uc_mask)))
              == ($past(err_uncorr) & ~$past(uc_mask))));

  // R8: no interrupt without uncorrectable status
  p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (rst)
    (uc_status == '0) |-> !irq_uncorr);
endmodule

bind ecc_err_aggregator ecc_err_aggregator_chk #(.N_SRAM(N_SRAM), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .irq_uncorr (irq_uncorr),
  .err_uncorr (err_uncorr),
  .uc_status  (uc_status_w),
  .uc_mask    (uc_mask_w),
  .uc_count   (uc_count_w),
  .uc_clr_we  (uc_clr_we_w)
);

// File: tb/ecc_err_aggregator_tb.sv
`timescale 1ns/1ps
module ecc_err_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq_uncorr;
  logic [31:0] rsp_rdata, inj_corr, inj_uncorr;
  logic [31:0] err_corr = '0, err_uncorr = '0;

  always #2.5 clk = ~clk;

  ecc_err_aggregator u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_corr(err_corr),
    .err_uncorr(err_uncorr), .inj_corr(inj_corr), .inj_uncorr(inj_uncorr),
    .irq_uncorr(irq_uncorr)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench model, index 0 = uncorrectable, 1 = correctable
  logic [31:0] m_st[2], m_mask[2];
  int          m_cnt[2];
  localparam logic [5:0] UC = 6'h10, CE = 6'h24;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  // one cycle of error pulses, optionally with a clear write to path cs
  task automatic step(logic [31:0] uc, logic [31:0] ce, int cs, logic [31:0] cd);
    logic [31:0] ev[2];
    @(negedge clk);
    err_uncorr = uc; err_corr = ce;
    if (cs >= 0) begin
      req_valid = 1; req_write = 1; req_wdata = cd;
      req_addr = (cs == 0) ? UC + 6'h10 : CE + 6'h10;
    end
    ev[0] = uc; ev[1] = ce;
    for (int s = 0; s < 2; s++) begin
      logic [31:0] hit, clr;
      int b;
      hit = ev[s] & ~m_mask[s];
      clr = (cs == s) ? cd : 32'h0;
      b   = (cs == s && cd != 0) ? 0 : m_cnt[s];
      m_st[s]  = (m_st[s] & ~clr) | hit;
      m_cnt[s] = b + $countones(hit);
      if (m_cnt[s] > 255) m_cnt[s] = 255;
    end
    @(negedge clk);
    err_uncorr = '0; err_corr = '0; req_valid = 0; req_write = 0;
  endtask

  task automatic rd_path(int s, string tag);
    logic [5:0] b;
    b = (s == 0) ? UC : CE;
    rd(b + 6'h0C, m_st[s], tag);
    rd(b + 6'h08, 32'(m_cnt[s]), tag);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin m_st[s] = 0; m_mask[s] = 0; m_cnt[s] = 0; end
    @(negedge clk);
    chk("R1 ready low in reset", {31'b0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 ready after reset", {31'b0, req_ready}, 32'h1);
    chk("R1 irq after reset", {31'b0, irq_uncorr}, 32'h0);
    chk("R1 inj_uncorr after reset", inj_uncorr, 32'h0);
    chk("R1 inj_corr after reset", inj_corr, 32'h0);
    for (int a = 0; a < 16; a++) rd(6'(a*4), 32'h0, "R1 register reset value");

    // R2 injection enables
    wr(UC, 32'hA5A5_0001);
    chk("R2 inj_uncorr output", inj_uncorr, 32'hA5A5_0001);
    chk("R2 inj_corr untouched", inj_corr, 32'h0);
    wr(CE, 32'h0000_F00F);
    chk("R2 inj_corr output", inj_corr, 32'h0000_F00F);
    rd(UC, 32'hA5A5_0001, "R2 readback uc inject");
    rd(CE, 32'h0000_F00F, "R2 readback ce inject");
    wr(UC, 0); wr(CE, 0);

    // R3 status sets, R5 count by popcount, R8 irq
    step(32'h0000_0011, 32'h0, -1, 0);
    rd_path(0, "R3 uc status and R5 count");
    chk("R8 irq on uc status", {31'b0, irq_uncorr}, 32'h1);
    step(32'h0, 32'h8000_0000, -1, 0);
    rd_path(1, "R3 ce status and count");
    // R6 clear, R8 ce gives no irq
    step(32'h0, 32'h0, 0, 32'h0000_0011);
    chk("R8 no irq from ce status", {31'b0, irq_uncorr}, 32'h0);
    rd_path(0, "R6 uc cleared");
    rd(UC + 6'h10, 32'h0, "R6 clear reads zero");
    step(32'h0000_0003, 32'h0, -1, 0);
    step(32'h0, 32'h0, 0, 32'h0000_0001);
    rd_path(0, "R6 partial clear keeps bit1, count zero");

    // R4 mask
    wr(UC + 6'h04, 32'h0000_00F0); m_mask[0] = 32'hF0;
    step(32'h0000_00FF, 32'h0, -1, 0);
    rd_path(0, "R4 masked lines ignored");
    wr(UC + 6'h04, 32'hFFFF_FFFF); m_mask[0] = 32'hFFFF_FFFF;
    chk("R8 irq dropped when fully masked", {31'b0, irq_uncorr}, 32'h0);
    rd(UC + 6'h0C, m_st[0], "R4 status kept under mask");
    wr(UC + 6'h04, 32'h0); m_mask[0] = 0;
    chk("R8 irq returns on unmask", {31'b0, irq_uncorr}, 32'h1);

    // R5 saturation on the correctable path
    step(32'h0, 32'h0, 1, 32'hFFFF_FFFF);
    for (int i = 0; i < 7; i++) step(32'h0, 32'hFFFF_FFFF, -1, 0);
    rd(CE + 6'h08, 32'd224, "R5 count 224 before saturation");
    step(32'h0, 32'hFFFF_FFFF, -1, 0);
    rd(CE + 6'h08, 32'd255, "R5 saturate at 255");
    step(32'h0, 32'h0000_0001, -1, 0);
    rd(CE + 6'h08, 32'd255, "R5 stays saturated");
    wr(CE + 6'h08, 32'h0);
    rd(CE + 6'h08, 32'd255, "R5 count write ignored");
    chk("R8 ce saturation no irq change", {31'b0, irq_uncorr}, 32'h1);

    // R7 error beats clear
    step(32'h0, 32'h0, -1, 0);
    step(32'h0000_0104, 32'h0, -1, 0);
    step(32'h0000_0104, 32'h0, 0, 32'h0000_0104);
    rd_path(0, "R7 error wins over same-cycle clear");

    // R9 spare and unmapped
    wr(6'h38, 32'hDEAD_BEEF);
    rd(6'h38, 32'hDEAD_BEEF, "R9 spare readback");
    wr(6'h04, 32'h1234_5678);
    rd(6'h04, 32'h0, "R9 unmapped reads zero");
    rd(6'h3C, 32'h0, "R9 top unmapped reads zero");

    // R10 back-to-back reads
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 6'h38;
    exp_q.push_back(32'hDEAD_BEEF); tag_q.push_back("R10 back-to-back first");
    @(negedge clk);
    req_addr = UC + 6'h0C;
    exp_q.push_back(m_st[0]); tag_q.push_back("R10 back-to-back second");
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    chk("R10 all responses returned", 32'(exp_q.size()), 32'h0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule